// File: doc/BRIEF.md
# Video Line and Frame Timing Sequencer

This block derives horizontal-line and frame timing for a 60 Hz or a 50 Hz television standard directly from the system clock. The ideal line length is not a whole number of clocks, so a fixed-point accumulator adds a per-standard increment for each line. Its integer part sets the length of the next line, and its fraction is carried forward. Over many lines the average line length is therefore exact, while any single line is a whole number of clocks.

A line counter and a frame counter sit on top of the accumulator. The block gives one-cycle pulses for line start, the vertical-blank interrupt, frame start and a periodic audio-update tick. It also gives a vertical-blank level, an interlace field bit and the current line and frame numbers. The standard select is read only at frame boundaries, so a frame never mixes two standards.

Top module: `vid_timing_seq`

## Requirements
- R1: Each line lasts floor((F + INC) / 2^FRAC_W) clocks. F is the fraction carried from the previous line and starts at 0 after reset. INC is INC_60 (default 8791293) when the frame's standard is 60 Hz, or INC_50 (default 8864320) when it is 50 Hz. FRAC_W defaults to 12. The low FRAC_W bits of the sum are carried to the next line.
- R2: `line_start_o` is high for exactly the first clock of every line except the first line after reset. In that same clock `line_cnt_o` shows the new line number, which is the previous number plus one, or 0 after a wrap.
- R3: After line LINES-1 the line number returns to 0. LINES is LINES_60 (263) or LINES_50 (313) for the frame's standard. In the first clock of line 0, `frame_start_o` pulses and `frame_cnt_o` increments by one.
- R4: `vblank_irq_o` pulses in the first clock of line VBL_LINE (240). `vblank_o` is high from that clock until the first clock of line 0, where it goes low.
- R5: `field_o` equals bit 0 of `frame_cnt_o` while `interlace_en_i` is 1, and is 0 otherwise. It follows a change of `interlace_en_i` one clock later.
- R6: `audio_tick_o` pulses in the first clock of every line whose count of lines started since reset is a multiple of AUDIO_LINES (32). Frame wraps do not reset this count.
- R7: `std_sel_i` (0 = 60 Hz, 1 = 50 Hz) is sampled only during reset and in the last line's final clock, for the frame that follows. A change in mid-frame leaves the current frame's line total and line increments unchanged.
- R8: A synchronous active-high reset sets the line number, the frame number and the carried fraction to 0. It drives every pulse, `vblank_o` and `field_o` low.
- R9: Every pulse output is at most one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| std_sel_i | input | 1 | Standard select: 0 = 60 Hz, 1 = 50 Hz |
| interlace_en_i | input | 1 | Enables the field bit |
| line_start_o | output | 1 | Pulse in the first clock of a line |
| vblank_irq_o | output | 1 | Vertical-blank interrupt pulse |
| vblank_o | output | 1 | Vertical-blank level |
| frame_start_o | output | 1 | Pulse in the first clock of a frame |
| field_o | output | 1 | Interlace field bit |
| audio_tick_o | output | 1 | Audio-update tick pulse |
| line_cnt_o | output | LINE_W | Current line number |
| frame_cnt_o | output | FRAME_W | Frame count, wraps modulo 2^FRAME_W |

## Verification
The assertions assume that every line is at least two clocks long, that VBL_LINE lies between 1 and the smaller line total minus one, and that the increments are small enough for fraction plus increment to fit in ACC_W bits. The bench keeps within these limits by overriding the parameters with short lines of 5 to 7 clocks, 12 or 15 lines per frame, vertical blank at line 9 and a tick every 4 lines. It changes `std_sel_i` and `interlace_en_i` only on falling clock edges in the middle of a line, so whole frames can be simulated.

// File: rtl/vt_pkg.sv
package vt_pkg;
  typedef enum logic {
    STD_60 = 1'b0,
    STD_50 = 1'b1
  } vt_std_e;
endpackage

// File: rtl/vt_line_accum.sv
module vt_line_accum
  import vt_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int FRAC_W = 12,
  parameter int INC_60 = 8791293,
  parameter int INC_50 = 8864320,
  localparam int LEN_W = ACC_W - FRAC_W
) (
  input  logic    clk_i,
  input  logic    rst_i,
  input  vt_std_e std_rst_i,
  input  vt_std_e std_next_i,
  output logic    line_end_o
);
  localparam logic [ACC_W-1:0] INC60_V = ACC_W'(INC_60);
  localparam logic [ACC_W-1:0] INC50_V = ACC_W'(INC_50);

  logic [LEN_W-1:0]  cyc_q, len_q;
  logic [FRAC_W-1:0] frac_q;
  logic [ACC_W-1:0]  inc_run, inc_rst, sum;

  assign inc_run = (std_next_i == STD_50) ? INC50_V : INC60_V;
  assign inc_rst = (std_rst_i  == STD_50) ? INC50_V : INC60_V;
  assign sum     = {{LEN_W{1'b0}}, frac_q} + inc_run;
  assign line_end_o = (cyc_q == len_q - LEN_W'(1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cyc_q  <= '0;
      len_q  <= inc_rst[ACC_W-1:FRAC_W];
      frac_q <= inc_rst[FRAC_W-1:0];
    end else if (line_end_o) begin
      cyc_q  <= '0;
      len_q  <= sum[ACC_W-1:FRAC_W];
      frac_q <= sum[FRAC_W-1:0];
    end else begin
      cyc_q  <= cyc_q + LEN_W'(1);
    end
  end

  AST_CYC_IN_LINE: assert property (@(posedge clk_i) disable iff (rst_i)
    cyc_q < len_q) else $error("cycle beyond line length"); // R1
  AST_LINE_RESTART: assert property (@(posedge clk_i) disable iff (rst_i)
    line_end_o |=> (cyc_q == '0)) else $error("line did not restart"); // R1
endmodule

// File: rtl/vt_audio_tick.sv
module vt_audio_tick #(
  parameter int AUDIO_LINES = 32,
  localparam int CNT_W = (AUDIO_LINES > 1) ? $clog2(AUDIO_LINES) : 1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic line_end_i,
  output logic tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q == CNT_W'(AUDIO_LINES - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= line_end_i & wrap;
      if (line_end_i) cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
    end
  end

  AST_TICK_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |=> !tick_o) else $error("tick too wide"); // R9
endmodule

// File: rtl/vt_frame_ctrl.sv
module vt_frame_ctrl
  import vt_pkg::*;
#(
  parameter int LINES_60 = 263,
  parameter int LINES_50 = 313,
  parameter int VBL_LINE = 240,
  parameter int LINE_W   = 9,
  parameter int FRAME_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               line_end_i,
  input  vt_std_e            std_sel_i,
  input  logic               interlace_i,
  output vt_std_e            std_next_o,
  output logic               line_start_o,
  output logic               vblank_irq_o,
  output logic               vblank_o,
  output logic               frame_start_o,
  output logic               field_o,
  output logic [LINE_W-1:0]  line_o,
  output logic [FRAME_W-1:0] frame_o
);
  vt_std_e            std_q;
  logic [LINE_W-1:0]  last_line;
  logic               at_last, at_pre_vbl, wrap;
  logic [FRAME_W-1:0] frame_nxt;

  assign last_line  = (std_q == STD_50) ? LINE_W'(LINES_50 - 1) : LINE_W'(LINES_60 - 1);
  assign at_last    = (line_o == last_line);
  assign at_pre_vbl = (line_o == LINE_W'(VBL_LINE - 1));
  assign wrap       = line_end_i & at_last;
  assign frame_nxt  = frame_o + FRAME_W'(wrap);
  assign std_next_o = at_last ? std_sel_i : std_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      std_q         <= std_sel_i;
      line_o        <= '0;
      frame_o       <= '0;
      line_start_o  <= 1'b0;
      vblank_irq_o  <= 1'b0;
      vblank_o      <= 1'b0;
      frame_start_o <= 1'b0;
      field_o       <= 1'b0;
    end else begin
      line_start_o  <= line_end_i;
      frame_start_o <= wrap;
      vblank_irq_o  <= line_end_i & ~at_last & at_pre_vbl;
      frame_o       <= frame_nxt;
      field_o       <= interlace_i & frame_nxt[0];
      if (line_end_i) begin
        if (at_last) begin
          line_o   <= '0;
          std_q    <= std_sel_i;
          vblank_o <= 1'b0;
        end else begin
          line_o   <= line_o + LINE_W'(1);
          if (at_pre_vbl) vblank_o <= 1'b1;
        end
      end
    end
  end

  AST_LINE_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
    line_o <= last_line) else $error("line past frame end"); // R3
  AST_LINE_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    line_start_o |-> (line_o == '0) || (line_o == $past(line_o) + LINE_W'(1)))
    else $error("bad line step"); // R2
  AST_LS_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
    line_start_o |=> !line_start_o) else $error("line pulse too wide"); // R9
  AST_VBL_IRQ: assert property (@(posedge clk_i) disable iff (rst_i)
    vblank_irq_o |-> vblank_o && (line_o == LINE_W'(VBL_LINE))) else $error("irq off line"); // R4
  AST_FRAME_LINE0: assert property (@(posedge clk_i) disable iff (rst_i)
    frame_start_o |-> (line_o == '0) && !vblank_o) else $error("frame start off line 0"); // R3
  AST_STD_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (line_o != '0) |-> $stable(std_q)) else $error("standard changed mid-frame"); // R7
endmodule

// File: rtl/vid_timing_seq.sv
module vid_timing_seq
  import vt_pkg::*;
#(
  parameter int ACC_W       = 32,
  parameter int FRAC_W      = 12,
  parameter int INC_60      = 8791293,
  parameter int INC_50      = 8864320,
  parameter int LINES_60    = 263,
  parameter int LINES_50    = 313,
  parameter int VBL_LINE    = 240,
  parameter int AUDIO_LINES = 32,
  parameter int FRAME_W     = 16,
  localparam int LINE_MAX   = (LINES_60 > LINES_50) ? LINES_60 : LINES_50,
  localparam int LINE_W     = $clog2(LINE_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               std_sel_i,
  input  logic               interlace_en_i,
  output logic               line_start_o,
  output logic               vblank_irq_o,
  output logic               vblank_o,
  output logic               frame_start_o,
  output logic               field_o,
  output logic               audio_tick_o,
  output logic [LINE_W-1:0]  line_cnt_o,
  output logic [FRAME_W-1:0] frame_cnt_o
);
  vt_std_e std_in, std_next;
  logic    line_end;

  assign std_in = vt_std_e'(std_sel_i);

  vt_line_accum #(
    .ACC_W(ACC_W), .FRAC_W(FRAC_W), .INC_60(INC_60), .INC_50(INC_50)
  ) accum_i (
    .clk_i(clk_i), .rst_i(rst_i), .std_rst_i(std_in),
    .std_next_i(std_next), .line_end_o(line_end)
  );

  vt_frame_ctrl #(
    .LINES_60(LINES_60), .LINES_50(LINES_50), .VBL_LINE(VBL_LINE),
    .LINE_W(LINE_W), .FRAME_W(FRAME_W)
  ) frame_i (
    .clk_i(clk_i), .rst_i(rst_i), .line_end_i(line_end), .std_sel_i(std_in),
    .interlace_i(interlace_en_i), .std_next_o(std_next),
    .line_start_o(line_start_o), .vblank_irq_o(vblank_irq_o),
    .vblank_o(vblank_o), .frame_start_o(frame_start_o), .field_o(field_o),
    .line_o(line_cnt_o), .frame_o(frame_cnt_o)
  );

  vt_audio_tick #(.AUDIO_LINES(AUDIO_LINES)) audio_i (
    .clk_i(clk_i), .rst_i(rst_i), .line_end_i(line_end), .tick_o(audio_tick_o)
  );

  AST_TICK_ON_LINE: assert property (@(posedge clk_i) disable iff (rst_i)
    audio_tick_o |-> line_start_o) else $error("tick outside line start"); // R6
  AST_FS_ON_LINE: assert property (@(posedge clk_i) disable iff (rst_i)
    frame_start_o |-> line_start_o) else $error("frame start without line start"); // R3
endmodule

// File: tb/vid_timing_seq_tb_top.sv
module vid_timing_seq_tb_top;
  localparam int FW = 12;
  localparam int I60 = 21504;   // 5.25 clocks
  localparam int I50 = 26624;   // 6.5 clocks
  localparam int L60 = 12;
  localparam int L50 = 15;
  localparam int VBL = 9;
  localparam int AUD = 4;
  localparam int LW  = $clog2(L50 + 1);
  localparam int FRW = 8;
  localparam int LEN_TAB [8] = '{5, 5, 5, 6, 5, 5, 5, 6};

  logic clk = 1'b0, rst = 1'b1, std_sel = 1'b0, intl = 1'b0;
  logic line_start_o, vblank_irq_o, vblank_o, frame_start_o, field_o, audio_tick_o;
  logic [LW-1:0]  line_cnt_o;
  logic [FRW-1:0] frame_cnt_o;

  int ntot = 0, npass = 0;
  int frac, exp_len, line_ref, frame_ref, lines_seen, skip;
  bit std_ref;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vid_timing_seq #(
    .FRAC_W(FW), .INC_60(I60), .INC_50(I50), .LINES_60(L60), .LINES_50(L50),
    .VBL_LINE(VBL), .AUDIO_LINES(AUD), .FRAME_W(FRW)
  ) dut_i (
    .clk_i(clk), .rst_i(rst), .std_sel_i(std_sel), .interlace_en_i(intl),
    .line_start_o(line_start_o), .vblank_irq_o(vblank_irq_o), .vblank_o(vblank_o),
    .frame_start_o(frame_start_o), .field_o(field_o), .audio_tick_o(audio_tick_o),
    .line_cnt_o(line_cnt_o), .frame_cnt_o(frame_cnt_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    ntot++;
    if (ok) npass++;
    else $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
  endtask

  function automatic int inc_of(input bit s);
    return s ? I50 : I60;
  endfunction

  function automatic int tot_of(input bit s);
    return s ? L50 : L60;
  endfunction

  task automatic start_model(input bit s);
    int sum;
    sum = inc_of(s);
    exp_len = sum >> FW;
    frac = sum & ((1 << FW) - 1);
    std_ref = s;
    line_ref = 0; frame_ref = 0; lines_seen = 0; skip = 0;
  endtask

  task automatic run_lines(input int cnt, input bit use_tab);
    for (int k = 0; k < cnt; k++) begin
      int n, sum;
      bit wrap;
      n = skip;
      do begin
        @(negedge clk);
        n++;
      end while (!line_start_o && n < 200);
      if (use_tab && lines_seen < 8)
        chk(n == LEN_TAB[lines_seen], "R1 table", n, LEN_TAB[lines_seen]);
      chk(n == exp_len, (std_sel != std_ref) ? "R7 length" : "R1 length", n, exp_len);
      lines_seen++;
      wrap = (line_ref == tot_of(std_ref) - 1);
      line_ref = wrap ? 0 : line_ref + 1;
      if (wrap) begin
        frame_ref = (frame_ref + 1) % (1 << FRW);
        std_ref = std_sel;
      end
      chk(line_cnt_o == LW'(line_ref), "R2 line number", line_cnt_o, line_ref);
      chk(frame_start_o == wrap, "R3 frame start", frame_start_o, wrap);
      chk(frame_cnt_o == FRW'(frame_ref), "R3 frame count", frame_cnt_o, frame_ref);
      chk(vblank_irq_o == (line_ref == VBL), "R4 irq", vblank_irq_o, line_ref == VBL);
      chk(vblank_o == (line_ref >= VBL), "R4 level", vblank_o, line_ref >= VBL);
      chk(audio_tick_o == (lines_seen % AUD == 0), "R6 tick", audio_tick_o, lines_seen % AUD == 0);
      chk(field_o == (intl & frame_ref[0]), "R5 field", field_o, intl & frame_ref[0]);
      sum = frac + inc_of(std_ref);
      exp_len = sum >> FW;
      frac = sum & ((1 << FW) - 1);
      @(negedge clk);
      chk(!line_start_o && !frame_start_o && !vblank_irq_o && !audio_tick_o,
          "R9 pulse width", {line_start_o, frame_start_o, vblank_irq_o, audio_tick_o}, 0);
      skip = 1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(line_cnt_o == 0 && frame_cnt_o == 0, "R8 counters", {line_cnt_o, frame_cnt_o}, 0);
    chk(!line_start_o && !frame_start_o && !vblank_irq_o && !audio_tick_o && !vblank_o && !field_o,
        "R8 outputs", {line_start_o, frame_start_o, vblank_irq_o, audio_tick_o, vblank_o, field_o}, 0);
    start_model(1'b0);
    rst = 1'b0;
    run_lines(30, 1'b1);
    intl = 1'b1;
    run_lines(2, 1'b0);
    std_sel = 1'b1;
    run_lines(40, 1'b0);
    intl = 1'b0;
    run_lines(3, 1'b0);
    std_sel = 1'b0;
    run_lines(25, 1'b0);
    // Directed: reset in mid-frame with 50 Hz selected.
    std_sel = 1'b1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(line_cnt_o == 0 && frame_cnt_o == 0, "R8 mid reset counters", {line_cnt_o, frame_cnt_o}, 0);
    chk(!vblank_o && !field_o && !line_start_o, "R8 mid reset levels", {vblank_o, field_o, line_start_o}, 0);
    start_model(1'b1);
    rst = 1'b0;
    run_lines(20, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", npass, ntot);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", npass, ntot);
      $finish;
    end
  end
endmodule